// File: doc/BRIEF.md
# Clock Frequency Deviation Monitor (ppm window, dual path)

This block watches one clock and flags it as out of frequency when its rate drifts too far from a chosen zero-ppm reference clock. The reference is taken from a dedicated reference pin or from any one of several general clock inputs. Every clock input is oversampled by a fast core clock. A two-stage synchronizer and a rising-edge detector turn each sampled clock into single-cycle ticks.

Two measurement paths run side by side. The precise path counts monitored edges over a long gate of reference edges, so that one count is a fraction of a ppm. The fast path uses a gate 64 times shorter and a fixed coarse limit. Each path judges its own count with a small state machine. The states are OFF (path disabled), GOOD (within the window) and BAD (out of frequency). The transitions are:

- ENABLE: OFF to GOOD when the path's enable goes high.
- EXCEED: GOOD to BAD when a finished gate's deviation is above the limit.
- RECOVER: BAD to GOOD when a finished gate's deviation is at or below the release level.
- DISABLE: any state to OFF when the enable drops.

The live flag is the OR of the two paths. A sticky copy of it holds until software clears it.

Top module: `ppm_oof_monitor`

## Requirements
- R1: `ref_sel` picks the zero-ppm reference. A value of 1 to 4 selects `ref_in[ref_sel-1]`. A value of 0, or any value above 4, selects `ref_xtal`.
- R2: The precise path counts monitored rising edges over exactly `GATE_REF` reference rising edges. Its deviation is that count minus `GATE_REF`. A count is 0.5 ppm at the default parameters.
- R3: The window limit is `win_code * CNT_PER_STEP` counts, where one code step is 2 ppm. The precise path enters BAD when a finished gate has a deviation magnitude strictly above the limit.
- R4: From BAD, the precise path returns to GOOD only when a finished gate has a deviation magnitude at or below the limit minus `hyst_code * CNT_PER_STEP`. That release level floors at 0. Between the release level and the limit, the state is held.
- R5: The fast path counts monitored edges over `GATE_REF/64` reference edges. It enters BAD when the deviation magnitude from that gate length is above `FAST_LIM`. It returns to GOOD when the deviation magnitude is at or below `FAST_LIM`, with no hysteresis.
- R6: A path whose enable is low goes to OFF on the next clock and contributes 0. `oof_live` is the OR of the two path flags, so it reads 0 with both paths disabled.
- R7: `oof_sticky` is set on any cycle after `oof_live` is 1. It stays set until `sticky_clr` is seen while `oof_live` is 0. When the set and the clear coincide, the set wins.
- R8: During and right after reset, `oof_live` and `oof_sticky` are 0.
- R9: With its enable held, a path's flag changes only in the cycle after one of its gates finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_clk | input | 1 | Clock under observation |
| ref_xtal | input | 1 | Dedicated reference clock |
| ref_in | input | NUM_IN | General clock inputs usable as reference |
| ref_sel | input | $clog2(NUM_IN+1) | Reference choice, see R1 |
| prec_en | input | 1 | Precise path enable |
| fast_en | input | 1 | Fast path enable |
| win_code | input | 8 | Window half-width in 2 ppm steps |
| hyst_code | input | 4 | Hysteresis in 2 ppm steps |
| sticky_clr | input | 1 | Clears the sticky flag |
| oof_live | output | 1 | Current out-of-frequency state |
| oof_sticky | output | 1 | Latched out-of-frequency state |

## Verification
The monitored clock comes from a phase accumulator, so each precise gate holds an exact, known edge count. The deviation is first stepped up and then down across the window. The rising pass shows where the set threshold sits, and the falling pass shows where the release threshold sits, which tells the set level apart from the release level. Window codes are swept at a fixed deviation, and a hysteresis larger than the window tests the floor. Large positive and negative deviations separate the fast path's coarse limit from the precise one. Reference clocks of a different period on selected inputs show which source each `ref_sel` value uses.

// File: rtl/ppm_mon_pkg.sv
package ppm_mon_pkg;
    typedef enum logic [1:0] {
        JUDGE_OFF  = 2'd0,
        JUDGE_GOOD = 2'd1,
        JUDGE_BAD  = 2'd2
    } judge_state_t;
endpackage

// File: rtl/ppm_edge_sync.sv
module ppm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], sig_i};
    end

    assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/ppm_gate_counter.sv
module ppm_gate_counter #(
    parameter int GATE = 256,
    parameter int CW   = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_tick,
    input  logic          mon_tick,
    output logic          meas_valid_o,
    output logic [CW-1:0] meas_count_o
);
    localparam int RW = $clog2(GATE + 1);

    logic [RW-1:0] ref_cnt;
    logic [CW-1:0] mon_cnt;
    logic [CW-1:0] mon_next;

    // Saturate rather than wrap on a runaway monitored clock
    always_comb begin
        mon_next = mon_cnt;
        if (mon_tick && (mon_cnt != '1)) mon_next = mon_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt      <= '0;
            mon_cnt      <= '0;
            meas_valid_o <= 1'b0;
            meas_count_o <= '0;
        end else begin
            meas_valid_o <= 1'b0;
            if (ref_tick && (ref_cnt == RW'(GATE - 1))) begin
                meas_valid_o <= 1'b1;
                meas_count_o <= mon_next;
                mon_cnt      <= '0;
                ref_cnt      <= '0;
            end else begin
                if (ref_tick) ref_cnt <= ref_cnt + 1'b1;
                mon_cnt <= mon_next;
            end
        end
    end

    assert_gate_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cnt < RW'(GATE));
    assert_valid_on_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid_o |-> $past(ref_tick));
endmodule

// File: rtl/ppm_judge.sv
module ppm_judge
    import ppm_mon_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          meas_valid,
    input  logic [CW-1:0] meas_count,
    input  logic [CW-1:0] nominal,
    input  logic [CW-1:0] limit,
    input  logic [CW-1:0] release_lvl,
    output logic          flag_o
);
    judge_state_t state, state_nx;
    logic [CW-1:0] dev;

    always_comb begin
        dev = (meas_count >= nominal) ? (meas_count - nominal) : (nominal - meas_count);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            JUDGE_OFF:  if (en) state_nx = JUDGE_GOOD;
            JUDGE_GOOD: if (meas_valid && (dev > limit)) state_nx = JUDGE_BAD;
            JUDGE_BAD:  if (meas_valid && (dev <= release_lvl)) state_nx = JUDGE_GOOD;
            default:    state_nx = JUDGE_OFF;
        endcase
        if (!en) state_nx = JUDGE_OFF;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= JUDGE_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        flag_o = (state == JUDGE_BAD);
    end

    assert_off_when_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !flag_o);
    assert_flag_only_at_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$past(meas_valid)) |-> $stable(flag_o));
    assert_set_on_excess_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && meas_valid && (dev > limit)) |=> (flag_o || !$past(flag_o) && (state == JUDGE_BAD)));
    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && en && meas_valid && (dev <= release_lvl)) |=> !flag_o);
endmodule

// File: rtl/ppm_oof_monitor.sv
module ppm_oof_monitor #(
    parameter int NUM_IN       = 4,
    parameter int GATE_REF     = 2_000_000,
    parameter int FAST_DIV     = 64,
    parameter int CNT_PER_STEP = 4,
    parameter int FAST_LIM     = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         mon_clk,
    input  logic                         ref_xtal,
    input  logic [NUM_IN-1:0]            ref_in,
    input  logic [$clog2(NUM_IN+1)-1:0]  ref_sel,
    input  logic                         prec_en,
    input  logic                         fast_en,
    input  logic [7:0]                   win_code,
    input  logic [3:0]                   hyst_code,
    input  logic                         sticky_clr,
    output logic                         oof_live,
    output logic                         oof_sticky
);
    localparam int SW        = $clog2(NUM_IN + 1);
    localparam int FAST_GATE = GATE_REF / FAST_DIV;
    localparam int CW        = $clog2(GATE_REF * 8) + 1;

    logic          ref_raw;
    logic          ref_tick, mon_tick;
    logic          p_valid, f_valid;
    logic [CW-1:0] p_count, f_count;
    logic [CW-1:0] lim, hyst_cnt, rel;
    logic          p_flag, f_flag;

    always_comb begin
        ref_raw = ref_xtal;
        for (int k = 0; k < NUM_IN; k++) begin
            if (ref_sel == SW'(k + 1)) ref_raw = ref_in[k];
        end
    end

    ppm_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst_n(rst_n), .sig_i(ref_raw), .rise_o(ref_tick));
    ppm_edge_sync #(.STAGES(SYNC_STAGES)) u_mon_sync (
        .clk(clk), .rst_n(rst_n), .sig_i(mon_clk), .rise_o(mon_tick));

    ppm_gate_counter #(.GATE(GATE_REF), .CW(CW)) u_prec_cnt (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .mon_tick(mon_tick),
        .meas_valid_o(p_valid), .meas_count_o(p_count));
    ppm_gate_counter #(.GATE(FAST_GATE), .CW(CW)) u_fast_cnt (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .mon_tick(mon_tick),
        .meas_valid_o(f_valid), .meas_count_o(f_count));

    assign lim      = CW'(win_code)  * CW'(CNT_PER_STEP);
    assign hyst_cnt = CW'(hyst_code) * CW'(CNT_PER_STEP);
    assign rel      = (lim > hyst_cnt) ? (lim - hyst_cnt) : '0;

    ppm_judge #(.CW(CW)) u_prec_judge (
        .clk(clk), .rst_n(rst_n), .en(prec_en), .meas_valid(p_valid),
        .meas_count(p_count), .nominal(CW'(GATE_REF)), .limit(lim),
        .release_lvl(rel), .flag_o(p_flag));
    ppm_judge #(.CW(CW)) u_fast_judge (
        .clk(clk), .rst_n(rst_n), .en(fast_en), .meas_valid(f_valid),
        .meas_count(f_count), .nominal(CW'(FAST_GATE)), .limit(CW'(FAST_LIM)),
        .release_lvl(CW'(FAST_LIM)), .flag_o(f_flag));

    assign oof_live = p_flag | f_flag;

    always_ff @(posedge clk) begin
        if (!rst_n)          oof_sticky <= 1'b0;
        else if (oof_live)   oof_sticky <= 1'b1;
        else if (sticky_clr) oof_sticky <= 1'b0;
    end

    assert_sticky_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oof_live |=> oof_sticky);
    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (oof_sticky && !sticky_clr) |=> oof_sticky);
    assert_both_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!prec_en && !fast_en) |=> !oof_live);
    assert_reset_quiet_R8: assert property (@(posedge clk)
        !rst_n |=> (!oof_live && !oof_sticky));
endmodule

// File: tb/test_ppm_oof_monitor.sv
module test_ppm_oof_monitor;
    localparam int GATE = 256;
    localparam int D    = 4 * GATE;   // clk cycles per precise gate on a period-4 reference
    localparam int W4   = 2 * D + 40;
    localparam int W5   = 2 * 5 * GATE + 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mon_clk = 1'b0;
    logic       ref_xtal = 1'b0;
    logic [3:0] ref_in = '0;
    logic [2:0] ref_sel = '0;
    logic       prec_en = 1'b1;
    logic       fast_en = 1'b1;
    logic [7:0] win_code = 8'd4;
    logic [3:0] hyst_code = 4'd1;
    logic       sticky_clr = 1'b0;
    logic       oof_live, oof_sticky;

    int checks = 0;
    int fails = 0;
    int k_rate = GATE;
    int acc = 0;
    int ph4 = 0;
    int ph5 = 0;

    always #4 clk = ~clk;

    ppm_oof_monitor #(
        .NUM_IN(4), .GATE_REF(GATE), .FAST_DIV(64),
        .CNT_PER_STEP(1), .FAST_LIM(1), .SYNC_STAGES(2)
    ) i_ppm_oof_monitor (
        .clk(clk), .rst_n(rst_n), .mon_clk(mon_clk), .ref_xtal(ref_xtal),
        .ref_in(ref_in), .ref_sel(ref_sel), .prec_en(prec_en), .fast_en(fast_en),
        .win_code(win_code), .hyst_code(hyst_code), .sticky_clr(sticky_clr),
        .oof_live(oof_live), .oof_sticky(oof_sticky));

    // Accumulator gives exactly k_rate monitored pulses in any D consecutive cycles
    always @(negedge clk) begin
        if (acc + k_rate >= D) begin
            acc     <= acc + k_rate - D;
            mon_clk <= 1'b1;
        end else begin
            acc     <= acc + k_rate;
            mon_clk <= 1'b0;
        end
        ph4       <= (ph4 + 1) % 4;
        ph5       <= (ph5 + 1) % 5;
        ref_xtal  <= (ph4 == 0);
        ref_in[1] <= (ph4 == 0);
        ref_in[0] <= (ph5 == 0);
        ref_in[2] <= (ph5 == 0);
        ref_in[3] <= (ph5 == 0);
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic settle(input int cyc);
        repeat (cyc) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk) sticky_clr = 1'b1;
        @(negedge clk) sticky_clr = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R8 live in reset", oof_live, 1'b0);
        chk("R8 sticky in reset", oof_sticky, 1'b0);
        rst_n = 1'b1;
        settle(W4);
        chk("R2 zero deviation", oof_live, 1'b0);
        chk("R8 sticky after reset", oof_sticky, 1'b0);

        // R3 rising sweep: set when |dev| > 4
        for (int d = 1; d <= 7; d++) begin
            k_rate = GATE + d;
            settle(W4);
            chk($sformatf("R3 rise dev=%0d", d), oof_live, d > 4);
        end
        chk("R7 sticky after event", oof_sticky, 1'b1);
        // R4 falling sweep: release at |dev| <= 4-1
        for (int d = 6; d >= 0; d--) begin
            k_rate = GATE + d;
            settle(W4);
            chk($sformatf("R4 fall dev=%0d", d), oof_live, d >= 4);
        end
        k_rate = GATE - 5; settle(W4);
        chk("R3 negative dev=-5", oof_live, 1'b1);
        k_rate = GATE - 3; settle(W4);
        chk("R4 negative release dev=-3", oof_live, 1'b0);
        k_rate = GATE - 4; settle(W4);
        chk("R3 negative dev=-4 in window", oof_live, 1'b0);

        // R3 window code sweep at dev=3, no hysteresis
        hyst_code = 4'd0;
        k_rate = GATE + 3;
        win_code = 8'd1; settle(W4); chk("R3 win=1 dev=3", oof_live, 1'b1);
        win_code = 8'd2; settle(W4); chk("R3 win=2 dev=3", oof_live, 1'b1);
        win_code = 8'd3; settle(W4); chk("R4 win=3 dev=3 release", oof_live, 1'b0);
        win_code = 8'd8; settle(W4); chk("R3 win=8 dev=3", oof_live, 1'b0);

        // R4 release floor at 0
        win_code = 8'd4; hyst_code = 4'd10;
        k_rate = GATE + 6; settle(W4); chk("R3 dev=6 big hyst", oof_live, 1'b1);
        k_rate = GATE + 1; settle(W4); chk("R4 floor hold dev=1", oof_live, 1'b1);
        k_rate = GATE;     settle(W4); chk("R4 floor release dev=0", oof_live, 1'b0);

        // R7 sticky clear and set priority
        pulse_clr(); chk("R7 clear while quiet", oof_sticky, 1'b0);
        k_rate = GATE + 6; settle(W4);
        pulse_clr(); chk("R7 set beats clear", oof_sticky, 1'b1);
        k_rate = GATE; settle(W4);
        pulse_clr(); chk("R7 clear after recovery", oof_sticky, 1'b0);

        // R6 / R5 enables and fast path
        hyst_code = 4'd1;
        k_rate = GATE + 7; prec_en = 1'b0; settle(W4);
        chk("R6 precise disabled dev=7", oof_live, 1'b0);
        k_rate = GATE + 200; settle(W4);
        chk("R5 fast dev=200", oof_live, 1'b1);
        fast_en = 1'b0; settle(W4);
        chk("R6 both disabled dev=200", oof_live, 1'b0);
        prec_en = 1'b1; settle(W4);
        chk("R6 precise only dev=200", oof_live, 1'b1);
        prec_en = 1'b0; fast_en = 1'b1;
        k_rate = GATE + 40; settle(W4);
        chk("R5 fast coarse dev=40", oof_live, 1'b0);
        k_rate = GATE - 200; settle(W4);
        chk("R5 fast dev=-200", oof_live, 1'b1);

        // R1 reference selection, precise only, exact monitored rate
        fast_en = 1'b0; prec_en = 1'b1; k_rate = GATE;
        settle(W4);
        chk("R1 sel=0 xtal", oof_live, 1'b0);
        ref_sel = 3'd1; settle(W5); chk("R1 sel=1 in0 slow", oof_live, 1'b1);
        ref_sel = 3'd2; settle(W5); chk("R1 sel=2 in1 match", oof_live, 1'b0);
        ref_sel = 3'd3; settle(W5); chk("R1 sel=3 in2 slow", oof_live, 1'b1);
        ref_sel = 3'd6; settle(W5); chk("R1 sel=6 falls to xtal", oof_live, 1'b0);
        ref_sel = 3'd4; settle(W5); chk("R1 sel=4 in3 slow", oof_live, 1'b1);
        ref_sel = 3'd0; settle(W5); chk("R1 sel=0 back to xtal", oof_live, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule